// File: doc/BRIEF.md
# Monochrome Character Display Controller

This block turns a stored page of character codes into a serial black-and-white raster for a 640x480 monitor. A pixel clock drives a three-bit phase counter that splits each line into eight-pixel character slots. In each slot the block reads one code from its internal text store, looks up one row of that character's 8x16 glyph, and shifts the eight glyph bits out one per clock. The block also produces active-low horizontal and vertical sync and a display-enable flag. With the default geometry the screen holds 80 columns by 30 rows.

A host that runs on its own clock updates the text store through a write port. The strobe passes through a two-flop synchroniser. When a rising edge of the strobe coincides with all enable lines high, the address and data are placed in a one-entry buffer. The buffered write is committed inside a later character slot, at fixed phases that never collide with the display read. A write that arrives while the buffer is still full is discarded, and a sticky overflow flag is set.

Top module: `textmode_vga`

## Requirements
- R1: While reset is low, and up to the third rising edge after it is released, pix_o=0, hsync_n_o=1, vsync_n_o=1, de_o=0 and overflow_o=0. Rising edges after release are numbered n=1,2,...; the phase before edge n is (n-1) mod 8.
- R2: Slot s is read at edge 8s+1. After edge 8s+4+j (j=0..7), pix_o carries bit 7-j of the glyph row for slot s, so bits leave MSB first.
- R3: Slot s lies in column s mod H_TOTAL. de_o is high only for columns below H_VISIBLE. hsync_n_o is low for columns H_SYNC_FIRST..H_SYNC_LAST. The defaults are 100, 80 and 82..93.
- R4: Slot s lies on line (s div H_TOTAL) mod V_TOTAL. Only lines below V_VISIBLE are shown. vsync_n_o is low for lines V_SYNC_FIRST..V_SYNC_LAST. The defaults are 525, 480 and 490..491.
- R5: Whenever de_o is low, pix_o is 0.
- R6: A visible slot at column c on line L shows glyph row code XOR {L[3:0],L[3:0]}. The code is the text cell at address (L div 16)*H_VISIBLE + c.
- R7: A strobe rise that first reaches the inputs before edge e is captured at edge e+2. The capture sets pending. The next edge in phase 4 that follows the capture starts driving the buffered write for phases 5 to 7. This leaves the phase-4 cycle idle. The memory write enable is high only in phase 6. Pending clears at the phase-7 edge.
- R8: A strobe rise with any bit of host_en low is ignored. The text cell and overflow_o keep their values.
- R9: A capture at any edge while pending is set is dropped, including the edge that clears pending. It sets overflow_o, which then stays high until reset.
- R10: A committed write is shown from the next read of that cell onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Asynchronous host write strobe, active high |
| host_en | input | NUM_EN | Host enables; all must be high for a write |
| host_addr | input | ADDR_W | Text cell address |
| host_data | input | 8 | Character code to store |
| pix_o | output | 1 | Serial pixel, 1 = white |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Display enable, aligned with pix_o |
| overflow_o | output | 1 | Sticky dropped-write flag |

## Verification
The bench uses a reduced geometry: 8 slots per line and 40 lines, with four visible columns and two character rows. This keeps each frame short while every line and cell is compared bit by bit against a model of the text store. Glyph bytes that differ in every nibble, together with all-ones and all-zeros codes, show whether the bit order, the line-nibble mixing and blanking are right. Writes land at random addresses and phases, so commits fall before or after the cell's next read and test the exact commit slot. Strobes with one enable low, and two strobes two edges apart, separate the ignore path from the overflow path.

// File: rtl/vtx_pkg.sv
// Shared types and the glyph lookup for the character display controller.
// Assumes 8-pixel-wide, 16-line-tall glyphs and 8-bit character codes.
package vtx_pkg;
    localparam int GLYPH_H = 16;
    localparam int CODE_W  = 8;

    // Per-slot timing flags carried alongside the pixel data.
    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic de;
    } vtx_tmg_t;

    // Computed glyph table: row pattern for a code on a given glyph line.
    function automatic logic [7:0] glyph_row(input logic [CODE_W-1:0] code,
                                             input logic [3:0] gline);
        return code ^ {gline, gline};
    endfunction
endpackage

// File: rtl/vtx_timing.sv
// Raster timing: phase counter, character column and scanline counters,
// plus visibility and sync decode for the current slot.
// Assumes all limits fit in HCW/VCW bits and sync ranges are inside totals.
module vtx_timing #(
    parameter int H_TOTAL      = 100,
    parameter int H_VISIBLE    = 80,
    parameter int H_SYNC_FIRST = 82,
    parameter int H_SYNC_LAST  = 93,
    parameter int V_TOTAL      = 525,
    parameter int V_VISIBLE    = 480,
    parameter int V_SYNC_FIRST = 490,
    parameter int V_SYNC_LAST  = 491,
    parameter int HCW          = 7,
    parameter int VCW          = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [2:0]          phase,
    output logic [HCW-1:0]      col,
    output logic [VCW-1:0]      line,
    output logic                vis,
    output vtx_pkg::vtx_tmg_t   tmg
);
    localparam logic [HCW-1:0] COL_LAST = HCW'(H_TOTAL - 1);
    localparam logic [HCW-1:0] COL_VIS  = HCW'(H_VISIBLE);
    localparam logic [HCW-1:0] HS_A     = HCW'(H_SYNC_FIRST);
    localparam logic [HCW-1:0] HS_B     = HCW'(H_SYNC_LAST);
    localparam logic [VCW-1:0] LINE_LAST = VCW'(V_TOTAL - 1);
    localparam logic [VCW-1:0] LINE_VIS  = VCW'(V_VISIBLE);
    localparam logic [VCW-1:0] VS_A      = VCW'(V_SYNC_FIRST);
    localparam logic [VCW-1:0] VS_B      = VCW'(V_SYNC_LAST);

    logic h_vis, v_vis, h_sync, v_sync;

    // Purpose: advance phase each clock, column at phase 7, line at row end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            col   <= '0;
            line  <= '0;
        end else begin
            phase <= phase + 3'd1;
            if (phase == 3'd7) begin
                if (col == COL_LAST) begin
                    col  <= '0;
                    line <= (line == LINE_LAST) ? '0 : line + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

    // Purpose: decode visibility and sync windows for the current slot.
    always_comb begin
        h_vis  = (col < COL_VIS);
        v_vis  = (line < LINE_VIS);
        h_sync = (col >= HS_A) && (col <= HS_B);
        v_sync = (line >= VS_A) && (line <= VS_B);
        vis    = h_vis && v_vis;
        tmg.hsync_n = ~h_sync;
        tmg.vsync_n = ~v_sync;
        tmg.de      = h_vis && v_vis;
    end
endmodule

// File: rtl/vtx_host_port.sv
// Host write path: two-flop strobe synchroniser, one-entry write buffer,
// and the per-slot write schedule (idle at phase 4, drive 5..7, enable 6).
// Assumes address/data/enables are stable while the strobe is high.
module vtx_host_port #(
    parameter int ADDR_W = 12,
    parameter int NUM_EN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        phase,
    input  logic              host_wr,
    input  logic [NUM_EN-1:0] host_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              wr_drive,
    output logic              pending,
    output logic              overflow
);
    logic             s1, s2, s3;
    logic             hit;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]       data_q;

    // Purpose: bring the strobe into the pixel domain and keep history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {s3, s2, s1} <= 3'b000;
        end else begin
            {s3, s2, s1} <= {s2, s1, host_wr};
        end
    end

    assign hit = s2 & ~s3 & (&host_en);

    // Purpose: capture the write into the buffer and track the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (hit && !pending) begin
            pending <= 1'b1;
            addr_q  <= host_addr;
            data_q  <= host_data;
        end else if (wr_drive && phase == 3'd7) begin
            pending <= 1'b0;
        end
    end

    // Purpose: latch a dropped write as a sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (hit && pending) begin
            overflow <= 1'b1;
        end
    end

    // Purpose: open the drive window after the idle phase 4, close at phase 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_drive <= 1'b0;
        end else if (phase == 3'd4 && pending) begin
            wr_drive <= 1'b1;
        end else if (phase == 3'd7) begin
            wr_drive <= 1'b0;
        end
    end

    assign mem_we    = wr_drive && (phase == 3'd6);
    assign mem_waddr = wr_drive ? addr_q : '0;
    assign mem_wdata = wr_drive ? data_q : '0;
endmodule

// File: rtl/vtx_text_ram.sv
// Synchronous text store: one write port and one registered read port.
// Writes outside DEPTH are discarded; contents are not cleared by reset.
module vtx_text_ram #(
    parameter int DEPTH  = 2400,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Purpose: commit an in-range write.
    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: registered read of the requested cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
        end
    end
endmodule

// File: rtl/textmode_vga.sv
// Character display controller top: raster timing, text fetch in phase 0,
// glyph lookup in phase 1, shifter load in phase 2, registered outputs.
// Assumes V_VISIBLE is a multiple of 16 and the pixel clock is the only clock.
module textmode_vga #(
    parameter int H_TOTAL      = 100,
    parameter int H_VISIBLE    = 80,
    parameter int H_SYNC_FIRST = 82,
    parameter int H_SYNC_LAST  = 93,
    parameter int V_TOTAL      = 525,
    parameter int V_VISIBLE    = 480,
    parameter int V_SYNC_FIRST = 490,
    parameter int V_SYNC_LAST  = 491,
    parameter int NUM_EN       = 5,
    parameter int ADDR_W       = $clog2(H_VISIBLE * (V_VISIBLE / 16))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [NUM_EN-1:0] host_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_data,
    output logic              pix_o,
    output logic              hsync_n_o,
    output logic              vsync_n_o,
    output logic              de_o,
    output logic              overflow_o
);
    import vtx_pkg::*;

    localparam int HCW   = $clog2(H_TOTAL);
    localparam int VCW   = $clog2(V_TOTAL);
    localparam int DEPTH = H_VISIBLE * (V_VISIBLE / GLYPH_H);

    logic [2:0]        phase;
    logic [HCW-1:0]    col;
    logic [VCW-1:0]    line;
    logic              vis;
    vtx_tmg_t          tmg, tmg_q;
    logic              mem_we, wr_drive, wr_pending;
    logic [ADDR_W-1:0] mem_waddr, rd_addr;
    logic [7:0]        mem_wdata, code_q, font_q, sh;
    logic              sh_load;

    vtx_timing #(
        .H_TOTAL(H_TOTAL), .H_VISIBLE(H_VISIBLE),
        .H_SYNC_FIRST(H_SYNC_FIRST), .H_SYNC_LAST(H_SYNC_LAST),
        .V_TOTAL(V_TOTAL), .V_VISIBLE(V_VISIBLE),
        .V_SYNC_FIRST(V_SYNC_FIRST), .V_SYNC_LAST(V_SYNC_LAST),
        .HCW(HCW), .VCW(VCW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .phase(phase), .col(col),
        .line(line), .vis(vis), .tmg(tmg)
    );

    vtx_host_port #(.ADDR_W(ADDR_W), .NUM_EN(NUM_EN)) u_host (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .host_wr(host_wr), .host_en(host_en),
        .host_addr(host_addr), .host_data(host_data),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wr_drive(wr_drive), .pending(wr_pending), .overflow(overflow_o)
    );

    assign rd_addr = vis ? ADDR_W'(int'(line[VCW-1:4]) * H_VISIBLE + int'(col)) : '0;

    vtx_text_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(phase == 3'd0), .raddr(rd_addr), .rdata(code_q)
    );

    assign sh_load = (phase == 3'd2);

    // Purpose: glyph lookup in phase 1, forced to zero outside the display.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            font_q <= '0;
        end else if (phase == 3'd1) begin
            font_q <= vis ? glyph_row(code_q, line[3:0]) : 8'h00;
        end
    end

    // Purpose: load shifter and slot timing in phase 2, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            tmg_q <= '{hsync_n: 1'b1, vsync_n: 1'b1, de: 1'b0};
        end else if (sh_load) begin
            sh    <= font_q;
            tmg_q <= tmg;
        end else begin
            sh <= {sh[6:0], 1'b0};
        end
    end

    // Purpose: register serial pixel and timing so all outputs move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o     <= 1'b0;
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
            de_o      <= 1'b0;
        end else begin
            pix_o     <= sh[7];
            hsync_n_o <= tmg_q.hsync_n;
            vsync_n_o <= tmg_q.vsync_n;
            de_o      <= tmg_q.de;
        end
    end
endmodule

// File: rtl/textmode_vga_sva.sv
// Property checker for textmode_vga, attached by bind below.
module textmode_vga_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic       mem_we,
    input logic       wr_drive,
    input logic       pending,
    input logic       overflow,
    input logic       pix,
    input logic       de
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase == 3'($past(phase) + 3'd1)); // R2
    AST_BLACK_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> !pix); // R5
    AST_WE_PHASE6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase == 3'd6 && pending)); // R7
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drive |-> (phase == 3'd5 || phase == 3'd6 || phase == 3'd7)); // R7
    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_drive) |-> phase == 3'd5); // R7
    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_drive && phase == 3'd7) |=> !pending); // R7
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
endmodule

bind textmode_vga textmode_vga_sva u_sva (
    .clk(clk), .rst_n(rst_n), .phase(phase), .mem_we(mem_we),
    .wr_drive(wr_drive), .pending(wr_pending), .overflow(overflow_o),
    .pix(pix_o), .de(de_o)
);

// File: tb/textmode_vga_test.sv
module textmode_vga_test;
    localparam int HT = 8, HV = 4, HS0 = 5, HS1 = 6;
    localparam int VT = 40, VV = 32, VS0 = 34, VS1 = 35;
    localparam int NE = 5, AW = 3, CELLS = 8;

    logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
    logic [NE-1:0] host_en = '0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_data = '0;
    logic pix, hs_n, vs_n, de, ovf;

    textmode_vga #(
        .H_TOTAL(HT), .H_VISIBLE(HV), .H_SYNC_FIRST(HS0), .H_SYNC_LAST(HS1),
        .V_TOTAL(VT), .V_VISIBLE(VV), .V_SYNC_FIRST(VS0), .V_SYNC_LAST(VS1),
        .NUM_EN(NE), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_en(host_en),
        .host_addr(host_addr), .host_data(host_data), .pix_o(pix),
        .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de), .overflow_o(ovf)
    );

    always #4 clk = ~clk;

    int n = 0, vectors = 0, miscompares = 0;
    bit done = 1'b0;
    logic [7:0] model [CELLS];
    bit         valid [CELLS];
    int commit_edge = -1, clear_edge = -1, ovf_from = 1 << 30;
    int c_addr = 0;
    logic [7:0] c_data = '0;
    logic [7:0] exp_row [2];
    logic [2:0] exp_tm  [2];
    bit         exp_known [2];

    always @(posedge clk) n <= rst_n ? n + 1 : 0;

    function automatic logic [7:0] bench_glyph(input logic [7:0] c, input int ln);
        logic [3:0] f;
        f = 4'(ln % 16);
        return c ^ {f, f};
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        vectors++;
        if (act != exp_v) begin
            miscompares++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, n, act, exp_v);
        end
    endtask

    // Predict the fate of a capture at edge c (R7, R8, R9).
    function automatic void schedule(input int c, input int a, input logic [7:0] d,
                                     input logic [NE-1:0] en);
        int m;
        if (&en) begin
            if (c <= clear_edge) begin
                if (ovf_from > c) ovf_from = c;
            end else begin
                m = c + 1 + ((4 - (c % 8) + 8) % 8);
                commit_edge = m + 2;
                clear_edge  = m + 3;
                c_addr = a;
                c_data = d;
            end
        end
    endfunction

    // Reference model and output comparison, away from the active edge.
    always @(negedge clk) begin : cmp
        int s, col, ln, a, j;
        bit vis;
        if (!done) begin
            if (!rst_n) begin
                chk("R1 pix", int'(pix), 0);
                chk("R1 hsync", int'(hs_n), 1);
                chk("R1 vsync", int'(vs_n), 1);
                chk("R1 de", int'(de), 0);
                chk("R1 overflow", int'(ovf), 0);
            end else begin
                if (n == commit_edge) begin
                    model[c_addr] = c_data;      // R10
                    valid[c_addr] = 1'b1;
                end
                if (n >= 1 && (n - 1) % 8 == 0) begin
                    s   = (n - 1) / 8;
                    col = s % HT;
                    ln  = (s / HT) % VT;
                    vis = (col < HV) && (ln < VV);
                    if (vis) begin
                        a = (ln / 16) * HV + col;
                        exp_row[s % 2]   = bench_glyph(model[a], ln);
                        exp_known[s % 2] = valid[a];
                    end else begin
                        exp_row[s % 2]   = 8'h00;
                        exp_known[s % 2] = 1'b1;
                    end
                    exp_tm[s % 2] = {~(col >= HS0 && col <= HS1),
                                     ~(ln >= VS0 && ln <= VS1), vis};
                end
                if (n < 4) begin
                    chk("R1 pix", int'(pix), 0);
                    chk("R1 hsync", int'(hs_n), 1);
                    chk("R1 de", int'(de), 0);
                end else begin
                    s = (n - 4) / 8;
                    j = (n - 4) % 8;
                    chk("R3 hsync", int'(hs_n), int'(exp_tm[s % 2][2]));
                    chk("R4 vsync", int'(vs_n), int'(exp_tm[s % 2][1]));
                    chk("R3 R4 de", int'(de), int'(exp_tm[s % 2][0]));
                    if (!exp_tm[s % 2][0])
                        chk("R5 blank pixel", int'(pix), 0);
                    else if (exp_known[s % 2])
                        chk("R6 R2 pixel", int'(pix), int'(exp_row[s % 2][7 - j]));
                end
                chk("R9 overflow", int'(ovf), (n >= ovf_from) ? 1 : 0);
            end
        end
    end

    task automatic host_write(input int a, input logic [7:0] d, input logic [NE-1:0] en);
        schedule(n + 3, a, d, en);
        host_addr = AW'(a);
        host_data = d;
        host_en   = en;
        host_wr   = 1'b1;
        repeat (2) @(negedge clk);
        host_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Two rises two edges apart: the second lands while pending (R9).
    task automatic host_pair(input int a1, input logic [7:0] d1,
                             input int a2, input logic [7:0] d2);
        schedule(n + 3, a1, d1, '1);
        schedule(n + 5, a2, d2, '1);
        host_addr = AW'(a1); host_data = d1; host_en = '1; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk); host_wr = 1'b1;
        @(negedge clk); host_addr = AW'(a2); host_data = d2; host_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin : stim
        int seed_sink;
        logic [NE-1:0] en;
        seed_sink = $urandom(32'd20240613);
        for (int i = 0; i < CELLS; i++) valid[i] = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < CELLS; i++) begin
            host_write(i, 8'(8'h35 * (i + 1)), '1);   // R7 R10
            idle(20);
        end
        host_write(0, 8'hFF, '1); idle(20);           // R6 all ones
        host_write(1, 8'h00, '1); idle(20);           // R6 all zeros
        host_write(2, 8'hA5, 5'b10111); idle(20);     // R8 ignored
        host_pair(3, 8'h3C, 4, 8'hC3); idle(24);      // R9 second dropped
        host_write(2, 8'h0F, 5'b11110); idle(20);     // R8 again, flag unchanged
        for (int k = 0; k < 60; k++) begin
            en = '1;
            if ($urandom_range(0, 5) == 0) en[$urandom_range(0, NE - 1)] = 1'b0;
            host_write(int'($urandom_range(0, CELLS - 1)), 8'($urandom), en);
            idle(int'($urandom_range(20, 59)));
        end
        idle(2 * HT * VT * 8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule